// File: doc/BRIEF.md
# Ping-pong sample packet buffer

This block sits between a PCM frame master and a packet transport. It keeps two outbound sample banks and two inbound sample banks, each holding eight bytes, and works through them in even/odd ping-pong order. A 5-bit slot index names the bank (index bit 4) and the slot (index bits 2:0). Index bit 3 is set in every valid state, so valid index values are 8–15 for the even bank and 24–31 for the odd bank.

The frame master pulses `step_i` once per bit period. The block counts these strobes as 8 bit periods times 4 outer steps, which makes a 32-strobe cycle. At the first bit period of outer step 1 it hands one outbound byte to the serializer and stores the byte captured from the line. At the first bit period of outer step 2 it advances the index. When the advance clears index bit 3, a bank has been completed. The block then requests transmission of that inbound packet. At outer step 3 it re-arms reception of the drained outbound bank, but only when the transport does not own that bank. The transport fills the outbound banks and reads the inbound banks through plain byte ports.

A controller with two states sequences the block. In `ST_RUN` strobes are counted and the actions above take place. The transition `ST_RUN -> ST_SOF_HOLD` is taken at the first overflow after reset, when the initial-sync flag is still set. In `ST_SOF_HOLD` strobes are ignored. The transition `ST_SOF_HOLD -> ST_RUN` is taken on `sof_i`; it issues the held transmit request and clears the sync flag.

Top module: `pp_sample_buffer`

## Requirements
- R1: After reset the index is 8, all request outputs and `tx_byte_o` are 0, storage reads 0, and `tx_len_o` and `arm_len_o` both read 16. The first strobe counted after reset is bit period 0 of outer step 0, so the first exchange happens on the 9th strobe.
- R2: On the strobe at bit period 0 of outer step 1, `tx_byte_o` takes the outbound byte at {index bit 4, index bits 2:0} in the cycle after the strobe, and `rx_byte_i` is written to the inbound byte at the same place. Both transport ports use a 4-bit address {bank, slot}.
- R3: The index increments modulo 32 on the strobe at bit period 0 of outer step 2. Bit 3 is clear only between that increment and the following outer-step-3 check, and no exchange uses an invalid index.
- R4: When the increment clears bit 3, `tx_req_o` pulses for one cycle in the cycle after the strobe. `tx_bank_o` is 0 when the new index has bit 4 set (even bank done) and 1 when bit 4 is clear (odd bank done).
- R5: On the strobe at bit period 0 of outer step 3, if bit 3 is clear, the outbound bank whose data was just drained (0 if index bit 4 is set, 1 otherwise) is re-armed only when bit 7 (owned) of that bank's byte in `ob_stat_i` (bank b at bits 8b+7:8b) is clear. Index bit 3 is set again in either case.
- R6: A re-arm pulses `arm_req_o` for one cycle in the cycle after the strobe. It drives `arm_status_o` = (bank status AND 0x40) OR 0x88 and `arm_bank_o` = the bank.
- R7: While `pause_i` is high at the overflow strobe, no transmit request is issued. The index still advances and the re-arm still takes place.
- R8: The first overflow after reset enters `ST_SOF_HOLD` with no transmit request. Strobes in `ST_SOF_HOLD` are ignored. A cycle with `sof_i` high returns the block to `ST_RUN` and pulses `tx_req_o` in the next cycle. Later overflows request transmission without waiting.
- R9: `tx_req_o` and `arm_req_o` are never high in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_i | input | 1 | One-cycle strobe per bit period |
| sof_i | input | 1 | Start-of-frame strobe used for the initial sync |
| pause_i | input | 1 | Suppresses inbound transmit requests |
| rx_byte_i | input | 8 | Byte captured by the deserializer |
| tx_byte_o | output | 8 | Byte handed to the serializer |
| ob_wr_en_i | input | 1 | Transport write strobe for outbound storage |
| ob_wr_addr_i | input | 4 | Outbound write address {bank, slot} |
| ob_wr_data_i | input | 8 | Outbound write data |
| ib_rd_addr_i | input | 4 | Inbound read address {bank, slot} |
| ib_rd_data_o | output | 8 | Inbound read data (combinational) |
| ob_stat_i | input | 16 | Outbound bank status bytes; bit 7 of each means owned |
| tx_req_o | output | 1 | One-cycle inbound packet transmit request |
| tx_bank_o | output | 1 | Bank of the transmit request |
| tx_len_o | output | 5 | Inbound packet length, 16 |
| arm_req_o | output | 1 | One-cycle outbound receive arm request |
| arm_bank_o | output | 1 | Bank of the arm request |
| arm_status_o | output | 8 | Status byte to write into the armed descriptor |
| arm_len_o | output | 5 | Byte count for the armed descriptor, 16 |

## Verification
The properties assume that `ob_stat_i` does not change in the cycle of an outer-step-3 strobe. They also assume that `pause_i` is driven one full cycle before any overflow strobe. Finally, they assume that `step_i` is a single-cycle pulse, so that each bit period advances the position once. The stimulus keeps to these assumptions: it drives every input at a falling edge, separates strobes by an idle cycle, and changes `pause_i` and the status bytes only between frames. It also raises `sof_i` only while the block is holding.

// File: rtl/pp_pkg.sv
package pp_pkg;

    typedef enum logic [1:0] {
        ST_RUN      = 2'd0,
        ST_SOF_HOLD = 2'd1
    } pp_state_e;

    localparam int STAT_W = 8;
    localparam logic [STAT_W-1:0] KEEP_MASK = 8'h40;
    localparam logic [STAT_W-1:0] ARM_SET   = 8'h88;
    localparam int OWN_BIT = 7;

    function automatic logic [STAT_W-1:0] arm_word(input logic [STAT_W-1:0] cur);
        return (cur & KEEP_MASK) | ARM_SET;
    endfunction

endpackage

// File: rtl/pp_step_seq.sv
module pp_step_seq #(
    parameter int BIT_STEPS   = 8,
    parameter int OUTER_STEPS = 4,
    localparam int BW = $clog2(BIT_STEPS),
    localparam int OW = $clog2(OUTER_STEPS)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          adv,
    output logic [OW-1:0] outer_q,
    output logic          ph_xchg,
    output logic          ph_incr,
    output logic          ph_check
);
    logic [BW-1:0] bit_q, bit_n;
    logic [OW-1:0] outer_n;
    logic          bit_wrap, at_head;

    always_comb begin
        bit_wrap = (bit_q == BW'(BIT_STEPS - 1));
        bit_n    = bit_wrap ? '0 : bit_q + 1'b1;
        if (bit_wrap)
            outer_n = (outer_q == OW'(OUTER_STEPS - 1)) ? '0 : outer_q + 1'b1;
        else
            outer_n = outer_q;
        at_head  = adv && (bit_n == '0);
        ph_xchg  = at_head && (outer_n == OW'(1));
        ph_incr  = at_head && (outer_n == OW'(2));
        ph_check = at_head && (outer_n == OW'(3));
    end

    // reset to the last position so the first strobe opens a new cycle
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            bit_q   <= BW'(BIT_STEPS - 1);
            outer_q <= OW'(OUTER_STEPS - 1);
        end else if (adv) begin
            bit_q   <= bit_n;
            outer_q <= outer_n;
        end
    end
endmodule

// File: rtl/pp_bank_store.sv
module pp_bank_store #(
    parameter int SLOTS = 8,
    parameter int DW    = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int AW   = SW + 1,
    localparam int NB   = 2 * SLOTS
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          ob_we,
    input  logic [AW-1:0] ob_waddr,
    input  logic [DW-1:0] ob_wdata,
    input  logic          xchg_en,
    input  logic [AW-1:0] xchg_addr,
    input  logic [DW-1:0] rx_byte,
    input  logic [AW-1:0] ib_raddr,
    output logic [DW-1:0] ob_rdata,
    output logic [DW-1:0] ib_rdata
);
    logic [DW-1:0] ob_mem [NB];
    logic [DW-1:0] ib_mem [NB];

    for (genvar g = 0; g < NB; g++) begin : g_cell
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ob_mem[g] <= '0;
            else if (ob_we && ob_waddr == AW'(g))
                ob_mem[g] <= ob_wdata;
        end
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                ib_mem[g] <= '0;
            else if (xchg_en && xchg_addr == AW'(g))
                ib_mem[g] <= rx_byte;
        end
    end

    assign ob_rdata = ob_mem[xchg_addr];
    assign ib_rdata = ib_mem[ib_raddr];
endmodule

// File: rtl/pp_ctrl_fsm.sv
module pp_ctrl_fsm
    import pp_pkg::*;
#(
    parameter int SLOTS = 8,
    parameter int DW    = 8,
    localparam int SW   = $clog2(SLOTS),
    localparam int IW   = SW + 2
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                sof_i,
    input  logic                pause_i,
    input  logic                ph_xchg,
    input  logic                ph_incr,
    input  logic                ph_check,
    input  logic [DW-1:0]       ob_rdata,
    input  logic [2*STAT_W-1:0] ob_stat,
    output logic                adv,
    output logic [IW-1:0]       idx_q,
    output pp_state_e           state_q,
    output logic [DW-1:0]       tx_byte,
    output logic                tx_req,
    output logic                tx_bank,
    output logic                arm_req,
    output logic                arm_bank,
    output logic [STAT_W-1:0]   arm_status
);
    localparam int VB = SW;        // valid bit of the index
    localparam int BB = IW - 1;    // bank bit of the index

    pp_state_e         state_n;
    logic              sync_pend, hold_bank;
    logic [IW-1:0]     idx_inc;
    logic              ovf_now, chk_ovf, drained;
    logic [STAT_W-1:0] sel_stat;

    always_comb begin
        adv      = step_i && (state_q == ST_RUN);
        idx_inc  = idx_q + 1'b1;
        ovf_now  = ph_incr && !idx_inc[VB];
        chk_ovf  = ph_check && !idx_q[VB];
        drained  = ~idx_q[BB];
        sel_stat = drained ? ob_stat[STAT_W +: STAT_W] : ob_stat[0 +: STAT_W];
    end

    // next-state logic
    always_comb begin
        state_n = state_q;
        unique case (state_q)
            ST_RUN:      if (ovf_now && sync_pend) state_n = ST_SOF_HOLD;
            ST_SOF_HOLD: if (sof_i)                state_n = ST_RUN;
            default:                               state_n = ST_RUN;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_RUN;
        else        state_q <= state_n;
    end

    // index register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            idx_q <= IW'(1 << VB);
        else if (ph_incr)
            idx_q <= idx_inc;
        else if (chk_ovf)
            idx_q[VB] <= 1'b1;
    end

    // outputs and sync bookkeeping
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_byte    <= '0;
            tx_req     <= 1'b0;
            tx_bank    <= 1'b0;
            arm_req    <= 1'b0;
            arm_bank   <= 1'b0;
            arm_status <= '0;
            sync_pend  <= 1'b1;
            hold_bank  <= 1'b0;
        end else begin
            tx_req  <= 1'b0;
            arm_req <= 1'b0;
            unique case (state_q)
                ST_RUN: begin
                    if (ph_xchg)
                        tx_byte <= ob_rdata;
                    if (ovf_now) begin
                        if (sync_pend) begin
                            hold_bank <= ~idx_inc[BB];
                        end else begin
                            tx_req  <= !pause_i;
                            tx_bank <= ~idx_inc[BB];
                        end
                    end
                    if (chk_ovf && !sel_stat[OWN_BIT]) begin
                        arm_req    <= 1'b1;
                        arm_bank   <= drained;
                        arm_status <= arm_word(sel_stat);
                    end
                end
                ST_SOF_HOLD: begin
                    if (sof_i) begin
                        tx_req    <= !pause_i;
                        tx_bank   <= hold_bank;
                        sync_pend <= 1'b0;
                    end
                end
                default: ;
            endcase
        end
    end
endmodule

// File: rtl/pp_sample_buffer.sv
module pp_sample_buffer
    import pp_pkg::*;
#(
    parameter int SLOTS       = 8,
    parameter int DW          = 8,
    parameter int BIT_STEPS   = 8,
    parameter int OUTER_STEPS = 4,
    localparam int SW         = $clog2(SLOTS),
    localparam int AW         = SW + 1,
    localparam int IW         = SW + 2,
    localparam int OW         = $clog2(OUTER_STEPS),
    localparam int PKT_BYTES  = 2 * SLOTS,
    localparam int LW         = $clog2(PKT_BYTES + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                step_i,
    input  logic                sof_i,
    input  logic                pause_i,
    input  logic [DW-1:0]       rx_byte_i,
    output logic [DW-1:0]       tx_byte_o,
    input  logic                ob_wr_en_i,
    input  logic [AW-1:0]       ob_wr_addr_i,
    input  logic [DW-1:0]       ob_wr_data_i,
    input  logic [AW-1:0]       ib_rd_addr_i,
    output logic [DW-1:0]       ib_rd_data_o,
    input  logic [2*STAT_W-1:0] ob_stat_i,
    output logic                tx_req_o,
    output logic                tx_bank_o,
    output logic [LW-1:0]       tx_len_o,
    output logic                arm_req_o,
    output logic                arm_bank_o,
    output logic [STAT_W-1:0]   arm_status_o,
    output logic [LW-1:0]       arm_len_o
);
    logic          adv_w, ph_xchg, ph_incr, ph_check;
    logic [OW-1:0] outer_w;
    logic [IW-1:0] idx_w;
    logic [DW-1:0] ob_rdata;
    logic [AW-1:0] slot_addr;
    pp_state_e     state_w;

    assign slot_addr = {idx_w[IW-1], idx_w[SW-1:0]};
    assign tx_len_o  = LW'(PKT_BYTES);
    assign arm_len_o = LW'(PKT_BYTES);

    pp_step_seq #(.BIT_STEPS(BIT_STEPS), .OUTER_STEPS(OUTER_STEPS)) u_seq (
        .clk(clk), .rst_n(rst_n), .adv(adv_w), .outer_q(outer_w),
        .ph_xchg(ph_xchg), .ph_incr(ph_incr), .ph_check(ph_check)
    );

    pp_bank_store #(.SLOTS(SLOTS), .DW(DW)) u_store (
        .clk(clk), .rst_n(rst_n),
        .ob_we(ob_wr_en_i), .ob_waddr(ob_wr_addr_i), .ob_wdata(ob_wr_data_i),
        .xchg_en(ph_xchg), .xchg_addr(slot_addr), .rx_byte(rx_byte_i),
        .ib_raddr(ib_rd_addr_i), .ob_rdata(ob_rdata), .ib_rdata(ib_rd_data_o)
    );

    pp_ctrl_fsm #(.SLOTS(SLOTS), .DW(DW)) u_fsm (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .sof_i(sof_i),
        .pause_i(pause_i), .ph_xchg(ph_xchg), .ph_incr(ph_incr),
        .ph_check(ph_check), .ob_rdata(ob_rdata), .ob_stat(ob_stat_i),
        .adv(adv_w), .idx_q(idx_w), .state_q(state_w), .tx_byte(tx_byte_o),
        .tx_req(tx_req_o), .tx_bank(tx_bank_o), .arm_req(arm_req_o),
        .arm_bank(arm_bank_o), .arm_status(arm_status_o)
    );
endmodule

// File: rtl/pp_sample_buffer_chk.sv
module pp_sample_buffer_chk
    import pp_pkg::*;
#(
    parameter int OW = 2
) (
    input logic                clk,
    input logic                rst_n,
    input logic                sof_i,
    input logic                pause_i,
    input logic [2*STAT_W-1:0] ob_stat_i,
    input logic                idx_valid,
    input logic [OW-1:0]       outer,
    input pp_state_e           state,
    input logic                tx_req_o,
    input logic                arm_req_o,
    input logic                arm_bank_o,
    input logic [STAT_W-1:0]   arm_status_o
);
    // R3: the index leaves its valid range only between increment and check
    a_r3_idx_valid: assert property (@(posedge clk) disable iff (!rst_n)
        !idx_valid |-> (outer == OW'(2)));

    // R4: transmit request is a single-cycle pulse
    a_r4_tx_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |=> !tx_req_o);

    // R5: no re-arm of an owned bank
    a_r5_arm_owned: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req_o |-> !(arm_bank_o ? $past(ob_stat_i[STAT_W+OWN_BIT]) : $past(ob_stat_i[OWN_BIT])));

    // R6: armed status keeps only the toggle bit besides the set pattern
    a_r6_arm_status: assert property (@(posedge clk) disable iff (!rst_n)
        arm_req_o |-> (arm_status_o[7] && arm_status_o[3] && ((arm_status_o & 8'h37) == 8'h00)
                       && arm_status_o[6] == (arm_bank_o ? $past(ob_stat_i[STAT_W+6]) : $past(ob_stat_i[6]))));

    // R7: paused overflow issues nothing
    a_r7_pause: assert property (@(posedge clk) disable iff (!rst_n)
        tx_req_o |-> !$past(pause_i));

    // R8: holding without a start-of-frame strobe yields no transmit
    a_r8_hold_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_SOF_HOLD && !sof_i) |=> !tx_req_o);

    // R9: requests never coincide
    a_r9_exclusive: assert property (@(posedge clk) disable iff (!rst_n)
        !(tx_req_o && arm_req_o));
endmodule

bind pp_sample_buffer pp_sample_buffer_chk #(.OW(OW)) u_chk (
    .clk(clk), .rst_n(rst_n), .sof_i(sof_i), .pause_i(pause_i),
    .ob_stat_i(ob_stat_i), .idx_valid(idx_w[SW]), .outer(outer_w),
    .state(state_w), .tx_req_o(tx_req_o), .arm_req_o(arm_req_o),
    .arm_bank_o(arm_bank_o), .arm_status_o(arm_status_o)
);

// File: tb/sim_pp_sample_buffer.sv
`timescale 1ns/1ps
module sim_pp_sample_buffer;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        step_i = 1'b0, sof_i = 1'b0, pause_i = 1'b0;
    logic [7:0]  rx_byte_i = '0;
    logic [7:0]  tx_byte_o;
    logic        ob_wr_en_i = 1'b0;
    logic [3:0]  ob_wr_addr_i = '0;
    logic [7:0]  ob_wr_data_i = '0;
    logic [3:0]  ib_rd_addr_i = '0;
    logic [7:0]  ib_rd_data_o;
    logic [15:0] ob_stat_i = '0;
    logic        tx_req_o, tx_bank_o, arm_req_o, arm_bank_o;
    logic [4:0]  tx_len_o, arm_len_o;
    logic [7:0]  arm_status_o;

    int n_chk = 0;
    int n_bad = 0;

    always #2 clk = ~clk;

    pp_sample_buffer u0 (
        .clk(clk), .rst_n(rst_n), .step_i(step_i), .sof_i(sof_i), .pause_i(pause_i),
        .rx_byte_i(rx_byte_i), .tx_byte_o(tx_byte_o), .ob_wr_en_i(ob_wr_en_i),
        .ob_wr_addr_i(ob_wr_addr_i), .ob_wr_data_i(ob_wr_data_i),
        .ib_rd_addr_i(ib_rd_addr_i), .ib_rd_data_o(ib_rd_data_o), .ob_stat_i(ob_stat_i),
        .tx_req_o(tx_req_o), .tx_bank_o(tx_bank_o), .tx_len_o(tx_len_o),
        .arm_req_o(arm_req_o), .arm_bank_o(arm_bank_o), .arm_status_o(arm_status_o),
        .arm_len_o(arm_len_o)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // one strobe; outputs are sampled at the falling edge after it
    task automatic strobe(input logic [7:0] rx);
        @(negedge clk);
        step_i = 1'b1;
        rx_byte_i = rx;
        @(negedge clk);
        step_i = 1'b0;
    endtask

    task automatic run_frame(input logic [7:0] rx, output int ntx, output logic txb,
                             output int narm, output logic armb, output logic [7:0] arms,
                             output logic [7:0] xbyte);
        ntx = 0; narm = 0; txb = 1'b0; armb = 1'b0; arms = '0; xbyte = '0;
        for (int s = 1; s <= 32; s++) begin
            strobe(rx);
            if (tx_req_o)  begin ntx++; txb = tx_bank_o; end
            if (arm_req_o) begin narm++; armb = arm_bank_o; arms = arm_status_o; end
            if (s == 9) xbyte = tx_byte_o;
        end
    endtask

    task automatic fill_outbound();
        for (int i = 0; i < 16; i++) begin
            @(negedge clk);
            ob_wr_en_i = 1'b1;
            ob_wr_addr_i = 4'(i);
            ob_wr_data_i = (i < 8) ? 8'(8'hA0 + i) : 8'(8'hB0 + i - 8);
        end
        @(negedge clk);
        ob_wr_en_i = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1 tx_req", tx_req_o, 0);
        chk("R1 arm_req", arm_req_o, 0);
        chk("R1 tx_byte", tx_byte_o, 0);
        chk("R1 tx_len", tx_len_o, 16);
        chk("R1 arm_len", arm_len_o, 16);
        ib_rd_addr_i = 4'd5;
        #1 chk("R1 inbound clear", ib_rd_data_o, 0);
    endtask

    task automatic t_even_sync();
        int ntx, narm; logic txb, armb; logic [7:0] arms, xb;
        ob_stat_i = {8'h80, 8'h45};
        for (int f = 0; f < 7; f++) begin
            run_frame(8'(8'h50 + f), ntx, txb, narm, armb, arms, xb);
            chk("R2 even exchange", xb, 8'(8'hA0 + f));
            chk("R3 no early overflow", 32'(ntx + narm), 0);
        end
        for (int s = 1; s <= 17; s++) begin
            strobe(8'h57);
            if (s == 9)  chk("R2 last even slot", tx_byte_o, 8'hA7);
            if (s == 17) chk("R8 held overflow no tx", tx_req_o, 0);
        end
        for (int s = 0; s < 3; s++) begin
            strobe(8'hEE);
            chk("R8 strobe ignored in hold", 32'({tx_req_o, arm_req_o}), 0);
        end
        @(negedge clk); sof_i = 1'b1;
        @(negedge clk); sof_i = 1'b0;
        chk("R8 sof releases tx", tx_req_o, 1);
        chk("R4 even bank done", tx_bank_o, 0);
        for (int s = 1; s <= 15; s++) begin
            strobe(8'h00);
            if (s < 8)  chk("R5 no early arm", arm_req_o, 0);
            if (s == 8) begin
                chk("R5 arm free even bank", arm_req_o, 1);
                chk("R5 arm bank", arm_bank_o, 0);
                chk("R6 arm status", arm_status_o, 8'hC8);
            end
        end
        for (int i = 0; i < 8; i++) begin
            ib_rd_addr_i = 4'(i);
            #1 chk("R2 inbound even stored", ib_rd_data_o, 8'(8'h50 + i));
        end
    endtask

    task automatic t_odd_owned();
        int ntx, narm; logic txb, armb; logic [7:0] arms, xb;
        int tx_tot = 0, arm_tot = 0; logic last_txb = 1'b0;
        for (int f = 0; f < 8; f++) begin
            run_frame(8'(8'h60 + f), ntx, txb, narm, armb, arms, xb);
            chk("R2 odd exchange", xb, 8'(8'hB0 + f));
            tx_tot += ntx; arm_tot += narm;
            if (ntx != 0) last_txb = txb;
        end
        chk("R4 odd overflow single tx", tx_tot, 1);
        chk("R4 odd bank done", last_txb, 1);
        chk("R5 owned bank not armed", arm_tot, 0);
        for (int i = 0; i < 8; i++) begin
            ib_rd_addr_i = 4'(8 + i);
            #1 chk("R2 inbound odd stored", ib_rd_data_o, 8'(8'h60 + i));
        end
    endtask

    task automatic t_pause();
        int ntx, narm; logic txb, armb; logic [7:0] arms, xb;
        int tx_tot = 0, arm_tot = 0;
        logic armb_l = 1'b1; logic [7:0] arms_l = '0;
        ob_stat_i = {8'h80, 8'h07};
        @(negedge clk); pause_i = 1'b1;
        for (int f = 0; f < 8; f++) begin
            run_frame(8'(8'h70 + f), ntx, txb, narm, armb, arms, xb);
            chk("R5 index back to even after skip", xb, 8'(8'hA0 + f));
            tx_tot += ntx; arm_tot += narm;
            if (narm != 0) begin armb_l = armb; arms_l = arms; end
        end
        chk("R7 paused no tx", tx_tot, 0);
        chk("R7 arm continues", arm_tot, 1);
        chk("R6 arm bank even", armb_l, 0);
        chk("R6 toggle cleared status", arms_l, 8'h88);
        @(negedge clk); pause_i = 1'b0;
        run_frame(8'h00, ntx, txb, narm, armb, arms, xb);
        chk("R7 index advanced to odd", xb, 8'hB0);
        chk("R9 no requests mid bank", 32'(ntx + narm), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog expired actual=running expected=done");
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        fill_outbound();
        t_even_sync();
        t_odd_owned();
        t_pause();
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule